// File: doc/BRIEF.md
# Interrupt Capture and Replay Controller

This block sits between a bank of external interrupt lines and a parent interrupt controller. Each line has its own mask, trigger type (edge or level, with a polarity) and a pending flag. The pending flag is set whenever the line sees its trigger condition. This happens whether or not the block is enabled and whether or not the line is masked. Software can therefore leave the block recording while the rest of the system is powered down, and have the recorded events delivered later.

When the block is disabled and no replay is running, unmasked lines pass straight through to the parent after polarity correction. When it is enabled, the parent outputs stay quiet and the block only records. A flush command walks the lines in ascending order, one per clock. For each line that is pending and unmasked, it emits a one-cycle pulse on that line's output and then retires the pending flag. Configuration uses a small word-addressed register bus with write-one-to-set, write-one-to-clear and write-one-to-acknowledge banks.

Top module: `irq_capture_replay`

## Requirements
- R1: After reset every pending flag is 0, every line is masked, every sensitivity bit is 0, every polarity bit is 1, the control register reads 0 and `irq_out` is all zero.
- R2: Line n lives in bank word offset + 4*(n/32), bit n%32. The mask pair is at 0x0C0 (set) and 0x100 (clear), sensitivity at 0x180/0x1C0 and polarity at 0x240/0x280. A 1 acts on its line, a 0 leaves it unchanged, and reading either offset of a pair returns the current state.
- R3: Polarity 1 with sensitivity 0 records a rising edge, and polarity 0 with sensitivity 0 records a falling edge. Sensitivity 1 records continuously while the input equals the polarity bit. An edge-type line ignores the opposite edge.
- R4: A trigger sets the line's pending flag by the third rising clock edge after the input change (two synchroniser stages plus capture), regardless of the enable bit and the mask. Pending flags read at 0x040.
- R5: Writing 1s to 0x040 (and following words) clears exactly those pending flags and leaves the others.
- R6: Control register 0x300 bit 1 (edge-only) stops level-sensitive lines from being recorded while edge-sensitive lines still record. Clearing it lets active level lines record again.
- R7: A write to 0x300 with bit 2 set starts a replay when none is running. On the N cycles that follow, lines 0 to N-1 are visited in order, one per cycle. A visited line that is pending and unmasked drives its `irq_out` bit high for that cycle only and has its pending flag cleared. Masked pending lines stay pending.
- R8: Control bit 2 reads 1 during a replay and 0 after it. A flush written during a replay does not restart it. At most one `irq_out` bit is high during a replay.
- R9: With control bit 0 (enable) clear and no replay running, `irq_out[n]` equals `!mask[n] && (irq_in[n] == polarity[n])`, combinationally.
- R10: With the enable bit set and no replay running, `irq_out` is all zero.
- R11: The following read as 0: unmapped addresses, misaligned addresses, bank words beyond the line count, bit positions at or above N, and control bits above bit 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 12 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_in | input | NUM_LINES | Asynchronous external interrupt lines |
| irq_out | output | NUM_LINES | Lines toward the parent controller |

## Verification
The bench builds the block with NUM_LINES = 40. This choice places lines on both sides of the 32-bit word boundary and leaves a partly used second word, so the word/bit addressing and the zero fill of unused bits are both exercised. A 40-line replay is short enough to check every visited cycle of several randomized flushes. Those flushes use random pending and mask patterns, and one of them receives a second flush command part way through.

// File: rtl/icr_pkg.sv
package icr_pkg;

    localparam int unsigned BUS_AW = 12;
    localparam int unsigned BUS_DW = 32;

    // Bank base offsets; software decodes these, so they are fixed.
    localparam logic [BUS_AW-1:0] OFS_ACK  = 12'h040;
    localparam logic [BUS_AW-1:0] OFS_MSET = 12'h0C0;
    localparam logic [BUS_AW-1:0] OFS_MCLR = 12'h100;
    localparam logic [BUS_AW-1:0] OFS_SSET = 12'h180;
    localparam logic [BUS_AW-1:0] OFS_SCLR = 12'h1C0;
    localparam logic [BUS_AW-1:0] OFS_PSET = 12'h240;
    localparam logic [BUS_AW-1:0] OFS_PCLR = 12'h280;
    localparam logic [BUS_AW-1:0] OFS_CTRL = 12'h300;

    localparam int unsigned CTL_EN    = 0;
    localparam int unsigned CTL_EONLY = 1;
    localparam int unsigned CTL_FLUSH = 2;

    typedef enum logic [3:0] {
        BK_NONE,
        BK_ACK,
        BK_MSET,
        BK_MCLR,
        BK_SSET,
        BK_SCLR,
        BK_PSET,
        BK_PCLR,
        BK_CTRL
    } bank_e;

endpackage

// File: rtl/icr_sync.sv
module icr_sync #(
    parameter int unsigned WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] meta_d, meta_q;
    logic [WIDTH-1:0] sync_d, sync_q;

    always_comb begin
        meta_d = async_in;
        sync_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= meta_d;
            sync_q <= sync_d;
        end
    end

    assign sync_out = sync_q;

endmodule

// File: rtl/icr_detect.sv
module icr_detect #(
    parameter int unsigned WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] line_sync,
    input  logic [WIDTH-1:0] pol,
    input  logic [WIDTH-1:0] sens,
    input  logic             edge_only,
    output logic [WIDTH-1:0] evt
);

    logic [WIDTH-1:0] act;
    logic [WIDTH-1:0] act_d, act_q;

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        // Polarity folded in: a line is active when it equals its polarity bit.
        assign act[i] = ~(line_sync[i] ^ pol[i]);
        assign evt[i] = sens[i] ? (act[i] & ~edge_only)
                                : (act[i] & ~act_q[i]);
    end

    always_comb begin
        act_d = act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '0;
        end else begin
            act_q <= act_d;
        end
    end

endmodule

// File: rtl/icr_decode.sv
module icr_decode
    import icr_pkg::*;
#(
    parameter int unsigned WORDS = 1
) (
    input  logic [BUS_AW-1:0] addr,
    output bank_e             bank,
    output logic [WORDS-1:0]  word_sel
);

    logic [BUS_AW-1:0] base;

    always_comb begin
        base = {addr[BUS_AW-1:6], 6'b0};
        word_sel = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (int'(addr[5:2]) == w) begin
                word_sel[w] = 1'b1;
            end
        end
        case (base)
            OFS_ACK:  bank = BK_ACK;
            OFS_MSET: bank = BK_MSET;
            OFS_MCLR: bank = BK_MCLR;
            OFS_SSET: bank = BK_SSET;
            OFS_SCLR: bank = BK_SCLR;
            OFS_PSET: bank = BK_PSET;
            OFS_PCLR: bank = BK_PCLR;
            OFS_CTRL: bank = (addr[5:0] == 6'd0) ? BK_CTRL : BK_NONE;
            default:  bank = BK_NONE;
        endcase
        if (addr[1:0] != 2'b00) begin
            bank = BK_NONE;
        end else if (bank != BK_CTRL && word_sel == '0) begin
            bank = BK_NONE;
        end
    end

endmodule

// File: rtl/irq_capture_replay.sv
module irq_capture_replay
    import icr_pkg::*;
#(
    parameter int unsigned NUM_LINES = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [11:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic [NUM_LINES-1:0] irq_out
);

    localparam int unsigned WORDS    = (NUM_LINES + BUS_DW - 1) / BUS_DW;
    localparam int unsigned PAD_W    = WORDS * BUS_DW;
    localparam int unsigned IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

    typedef struct packed {
        logic [NUM_LINES-1:0] mask;
        logic [NUM_LINES-1:0] sens;
        logic [NUM_LINES-1:0] pol;
        logic [NUM_LINES-1:0] pend;
        logic                 en;
        logic                 edge_only;
        logic                 flushing;
        logic [IDX_W-1:0]     idx;
    } state_t;

    state_t state_d, state_q;

    bank_e                bank;
    logic [WORDS-1:0]     word_sel;
    logic [NUM_LINES-1:0] line_sync;
    logic [NUM_LINES-1:0] line_evt;
    logic [NUM_LINES-1:0] wr_lines;
    logic [NUM_LINES-1:0] ack_clr;
    logic [NUM_LINES-1:0] replay_hit;
    logic [PAD_W-1:0]     rd_src;
    logic                 ctrl_en;
    logic                 flush_active;
    logic [IDX_W-1:0]     flush_idx;
    logic                 ctrl_wr;

    assign ctrl_en      = state_q.en;
    assign flush_active = state_q.flushing;
    assign flush_idx    = state_q.idx;

    icr_decode #(.WORDS(WORDS)) u_decode (
        .addr     (bus_addr),
        .bank     (bank),
        .word_sel (word_sel)
    );

    icr_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_in),
        .sync_out (line_sync)
    );

    icr_detect #(.WIDTH(NUM_LINES)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_sync (line_sync),
        .pol       (state_q.pol),
        .sens      (state_q.sens),
        .edge_only (state_q.edge_only),
        .evt       (line_evt)
    );

    // Line currently visited by the replay scan, if it is due a pulse.
    always_comb begin
        replay_hit = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (flush_active && flush_idx == IDX_W'(i)) begin
                replay_hit[i] = state_q.pend[i] & ~state_q.mask[i];
            end
        end
    end

    // Next-state computation.
    always_comb begin
        state_d = state_q;
        ctrl_wr = bus_we && (bank == BK_CTRL);
        for (int i = 0; i < NUM_LINES; i++) begin
            wr_lines[i] = word_sel[i / BUS_DW] & bus_wdata[i % BUS_DW];
        end
        ack_clr = '0;
        if (bus_we) begin
            case (bank)
                BK_ACK:  ack_clr        = wr_lines;
                BK_MSET: state_d.mask   = state_q.mask | wr_lines;
                BK_MCLR: state_d.mask   = state_q.mask & ~wr_lines;
                BK_SSET: state_d.sens   = state_q.sens | wr_lines;
                BK_SCLR: state_d.sens   = state_q.sens & ~wr_lines;
                BK_PSET: state_d.pol    = state_q.pol | wr_lines;
                BK_PCLR: state_d.pol    = state_q.pol & ~wr_lines;
                BK_CTRL: begin
                    state_d.en        = bus_wdata[CTL_EN];
                    state_d.edge_only = bus_wdata[CTL_EONLY];
                end
                default: ;
            endcase
        end
        if (flush_active) begin
            if (flush_idx == LAST_IDX) begin
                state_d.flushing = 1'b0;
            end else begin
                state_d.idx = flush_idx + IDX_W'(1);
            end
        end else if (ctrl_wr && bus_wdata[CTL_FLUSH]) begin
            state_d.flushing = 1'b1;
            state_d.idx      = '0;
        end
        // A fresh event outranks acknowledge and replay retirement.
        state_d.pend = (state_q.pend & ~ack_clr & ~replay_hit) | line_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.mask      <= '1;
            state_q.sens      <= '0;
            state_q.pol       <= '1;
            state_q.pend      <= '0;
            state_q.en        <= 1'b0;
            state_q.edge_only <= 1'b0;
            state_q.flushing  <= 1'b0;
            state_q.idx       <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // Read path: both offsets of a pair return the stored state.
    always_comb begin
        case (bank)
            BK_ACK:           rd_src = PAD_W'(state_q.pend);
            BK_MSET, BK_MCLR: rd_src = PAD_W'(state_q.mask);
            BK_SSET, BK_SCLR: rd_src = PAD_W'(state_q.sens);
            BK_PSET, BK_PCLR: rd_src = PAD_W'(state_q.pol);
            default:          rd_src = '0;
        endcase
        bus_rdata = '0;
        if (bank == BK_CTRL) begin
            bus_rdata[CTL_EN]    = state_q.en;
            bus_rdata[CTL_EONLY] = state_q.edge_only;
            bus_rdata[CTL_FLUSH] = flush_active;
        end else begin
            for (int w = 0; w < WORDS; w++) begin
                if (word_sel[w]) begin
                    bus_rdata = rd_src[w * BUS_DW +: BUS_DW];
                end
            end
        end
    end

    // Parent-side outputs.
    always_comb begin
        if (flush_active) begin
            irq_out = replay_hit;
        end else if (ctrl_en) begin
            irq_out = '0;
        end else begin
            irq_out = ~state_q.mask & ~(irq_in ^ state_q.pol);
        end
    end

endmodule

// File: rtl/icr_chk.sv
module icr_chk #(
    parameter int unsigned NUM_LINES = 40
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_we,
    input logic [11:0]          bus_addr,
    input logic                 flush_req,
    input logic [NUM_LINES-1:0] irq_out,
    input logic                 ctrl_en,
    input logic                 flush_active,
    input logic [((NUM_LINES > 1) ? $clog2(NUM_LINES) : 1)-1:0] flush_idx
);

    localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_LINES - 1);

    logic ctrl_wr;
    assign ctrl_wr = bus_we && (bus_addr == 12'h300);

    // R8
    replay_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_active |-> $onehot0(irq_out));

    // R10
    enabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && !flush_active) |-> (irq_out == '0));

    // R7
    scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_active && flush_idx != LAST)
        |=> (flush_active && flush_idx == IDX_W'($past(flush_idx) + 1'b1)));

    // R7
    scan_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_active && flush_idx == LAST) |=> !flush_active);

    // R8
    flush_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_active && ctrl_wr && flush_req) |=> (flush_active && flush_idx == '0));

endmodule

bind irq_capture_replay icr_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .flush_req    (bus_wdata[2]),
    .irq_out      (irq_out),
    .ctrl_en      (ctrl_en),
    .flush_active (flush_active),
    .flush_idx    (flush_idx)
);

// File: tb/irq_capture_replay_bench.sv
`timescale 1ns/1ps
module irq_capture_replay_bench;

    localparam int N = 40;
    localparam logic [63:0] LMASK = (64'd1 << N) - 64'd1;
    localparam logic [63:0] ALL   = {64{1'b1}};
    localparam logic [11:0] A_ACK = 12'h040, A_MSET = 12'h0C0, A_MCLR = 12'h100;
    localparam logic [11:0] A_SSET = 12'h180, A_SCLR = 12'h1C0, A_PSET = 12'h240;
    localparam logic [11:0] A_PCLR = 12'h280, A_CTRL = 12'h300;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  irq_in = '0;
    logic [N-1:0]  irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [63:0] m_mask, m_sens, m_pol, m_pend;

    always #2.5 clk = ~clk;

    irq_capture_replay #(.NUM_LINES(N)) u_irq_capture_replay (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_in    (irq_in),
        .irq_out   (irq_out)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr_lines(input logic [11:0] base, input logic [63:0] v);
        wr(base, v[31:0]);
        wr(base + 12'd4, v[63:32]);
    endtask

    task automatic rd_lines(input logic [11:0] base, output logic [63:0] v);
        logic [31:0] lo, hi;
        rd(base, lo);
        rd(base + 12'd4, hi);
        v = {hi, lo};
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [63:0] pass_exp(input logic [N-1:0] in_v);
        return ~m_mask & ~({{(64-N){1'b0}}, in_v} ^ m_pol) & LMASK;
    endfunction

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom} & LMASK;
    endfunction

    task automatic quiesce();
        wr_lines(A_SCLR, ALL); m_sens = '0;
        wr_lines(A_PSET, ALL); m_pol = LMASK;
        irq_in = '0;
        idle(4);
        wr_lines(A_ACK, ALL); m_pend = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [63:0] v, v2, ev, pat, ackv;
        logic [31:0] d;
        void'($urandom(32'h5eed_1c0a));
        m_mask = LMASK; m_sens = '0; m_pol = LMASK; m_pend = '0;
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        rd_lines(A_ACK, v);  check("R1 pending", v, 64'd0);
        rd_lines(A_MSET, v); check("R1 mask", v, LMASK);
        rd_lines(A_SCLR, v); check("R1 sens", v, 64'd0);
        rd_lines(A_PCLR, v); check("R1 pol", v, LMASK);
        rd(A_CTRL, d);       check("R1 ctrl", {32'd0, d}, 64'd0);
        check("R1 irq_out", {{(64-N){1'b0}}, irq_out}, 64'd0);

        // R2: set/clear banks, random patterns
        for (int it = 0; it < 18; it++) begin
            int kind;
            kind = int'($urandom % 6);
            v = {$urandom, $urandom};
            case (kind)
                0: begin wr_lines(A_MSET, v); m_mask = m_mask | (v & LMASK); end
                1: begin wr_lines(A_MCLR, v); m_mask = m_mask & ~v; end
                2: begin wr_lines(A_SSET, v); m_sens = m_sens | (v & LMASK); end
                3: begin wr_lines(A_SCLR, v); m_sens = m_sens & ~v; end
                4: begin wr_lines(A_PSET, v); m_pol = m_pol | (v & LMASK); end
                default: begin wr_lines(A_PCLR, v); m_pol = m_pol & ~v; end
            endcase
            case (kind / 2)
                0: ev = m_mask;
                1: ev = m_sens;
                default: ev = m_pol;
            endcase
            rd_lines((kind / 2 == 0) ? A_MSET : (kind / 2 == 1) ? A_SSET : A_PSET, v2);
            check("R2 set-offset read", v2, ev);
            rd_lines((kind / 2 == 0) ? A_MCLR : (kind / 2 == 1) ? A_SCLR : A_PCLR, v2);
            check("R2 clear-offset read", v2, ev);
        end

        // R11: unmapped and out-of-range reads
        rd(12'h048, d); check("R11 word past lines", {32'd0, d}, 64'd0);
        rd(12'h304, d); check("R11 unmapped near ctrl", {32'd0, d}, 64'd0);
        rd(12'h000, d); check("R11 unmapped base", {32'd0, d}, 64'd0);
        rd(12'h0C2, d); check("R11 misaligned", {32'd0, d}, 64'd0);

        // R5: acknowledge everything after settling
        quiesce();
        rd_lines(A_ACK, v); check("R5 ack all clears", v, 64'd0);

        // R9: pass-through while disabled
        for (int it = 0; it < 10; it++) begin
            v = rnd64();
            wr_lines(A_MCLR, ALL); wr_lines(A_MSET, v); m_mask = v;
            v = rnd64();
            wr_lines(A_PSET, ALL); wr_lines(A_PCLR, v); m_pol = LMASK & ~v;
            irq_in = N'({$urandom, $urandom});
            #1;
            check("R9 pass-through", {{(64-N){1'b0}}, irq_out}, pass_exp(irq_in));
        end
        quiesce();
        wr_lines(A_MSET, ALL); m_mask = LMASK;

        // R3/R4 directed: line 5 falling, 33 level-high, 36 level-low
        irq_in[5] = 1'b1; irq_in[36] = 1'b1;
        idle(4);
        wr(A_PCLR, 32'h0000_0020);
        wr(A_SSET + 12'd4, 32'h0000_0012);
        wr(A_PCLR + 12'd4, 32'h0000_0010);
        idle(4);
        wr_lines(A_ACK, ALL);
        rd_lines(A_ACK, v); check("R5 ack after config", v, 64'd0);

        irq_in[3] = 1'b1; idle(4);
        rd_lines(A_ACK, v); check("R4 rising recorded while masked and disabled", v, 64'd1 << 3);
        wr(A_ACK, 32'h0000_0008);
        rd_lines(A_ACK, v); check("R5 ack clears line 3", v, 64'd0);
        irq_in[3] = 1'b0; idle(4);
        rd_lines(A_ACK, v); check("R3 falling ignored on rising line", v, 64'd0);

        irq_in[5] = 1'b0; idle(4);
        rd_lines(A_ACK, v); check("R3 falling edge line 5", v, 64'd1 << 5);
        wr_lines(A_ACK, ALL);

        irq_in[33] = 1'b1; idle(4);
        rd_lines(A_ACK, v); check("R3 level-high line 33", v, 64'd1 << 33);
        wr(A_ACK + 12'd4, 32'h0000_0002); idle(2);
        rd_lines(A_ACK, v); check("R3 level keeps recording", v, 64'd1 << 33);
        irq_in[33] = 1'b0; idle(4);
        wr_lines(A_ACK, ALL);
        rd_lines(A_ACK, v); check("R5 ack after level drop", v, 64'd0);

        irq_in[36] = 1'b0; idle(4);
        rd_lines(A_ACK, v); check("R3 level-low line 36", v, 64'd1 << 36);
        irq_in[36] = 1'b1; idle(4);
        wr_lines(A_ACK, ALL);

        // R6/R10: edge-only recording while enabled
        wr_lines(A_MCLR, ALL); m_mask = '0;
        wr(A_CTRL, 32'd3);
        irq_in[33] = 1'b1; irq_in[36] = 1'b0; irq_in[7] = 1'b1;
        idle(4);
        rd_lines(A_ACK, v); check("R6 edge-only skips level lines", v, 64'd1 << 7);
        check("R10 enabled outputs quiet", {{(64-N){1'b0}}, irq_out}, 64'd0);
        wr(A_CTRL, 32'd1);
        idle(3);
        rd_lines(A_ACK, v);
        check("R6 level lines record again", v, (64'd1 << 7) | (64'd1 << 33) | (64'd1 << 36));
        check("R10 enabled outputs quiet with active lines", {{(64-N){1'b0}}, irq_out}, 64'd0);
        irq_in[33] = 1'b0; irq_in[36] = 1'b1; irq_in[7] = 1'b0;
        idle(4);

        // R7/R8: randomized replay rounds, all lines rising-edge
        wr_lines(A_PSET, ALL); wr_lines(A_SCLR, ALL);
        m_pol = LMASK; m_sens = '0;
        irq_in = '0; idle(4);
        wr_lines(A_ACK, ALL); m_pend = '0;
        for (int r = 0; r < 6; r++) begin
            logic [63:0] m;
            pat = (r == 0) ? LMASK : rnd64();
            m = (r == 0) ? 64'd0 : rnd64();
            wr_lines(A_MCLR, ALL); wr_lines(A_MSET, m); m_mask = m;
            irq_in = pat[N-1:0]; idle(4);
            irq_in = '0; idle(4);
            m_pend = m_pend | pat;
            rd_lines(A_ACK, v); check("R4 pending before replay", v, m_pend);
            wr(A_CTRL, 32'd5);
            for (int k = 0; k < N; k++) begin
                #1;
                ev = (m_pend[k] && !m_mask[k]) ? (64'd1 << k) : 64'd0;
                check("R7 replay pulse", {{(64-N){1'b0}}, irq_out}, ev);
                if (k == 0) begin
                    rd(A_CTRL, d);
                    check("R8 flush bit reads busy", {32'd0, d}, 64'd5);
                end
                if (r == 1 && k == 5) begin
                    bus_we = 1'b1; bus_addr = A_CTRL; bus_wdata = 32'd5;
                end
                if (r == 1 && k == 6) bus_we = 1'b0;
                @(negedge clk);
            end
            rd(A_CTRL, d);
            check("R8 flush bit self-clears", {32'd0, d}, 64'd1);
            check("R10 quiet after replay", {{(64-N){1'b0}}, irq_out}, 64'd0);
            m_pend = m_pend & m_mask;
            rd_lines(A_ACK, v); check("R7 masked lines stay pending", v, m_pend);
        end

        // R5: partial acknowledge
        for (int it = 0; it < 4; it++) begin
            pat = rnd64();
            irq_in = pat[N-1:0]; idle(4);
            irq_in = '0; idle(4);
            m_pend = m_pend | pat;
            ackv = rnd64();
            wr_lines(A_ACK, ackv);
            m_pend = m_pend & ~ackv;
            rd_lines(A_ACK, v); check("R5 partial acknowledge", v, m_pend);
        end

        finish_run();
    end

endmodule